// File: doc/BRIEF.md
# Push-button stepped state sequencer

This block turns an unsynchronised, possibly bouncing push-button into exactly one step of a four-state sequencer per press. The raw button level first crosses into the system clock domain through a short flop chain. A hold filter then accepts a new level only after it has stayed steady for a set number of clocks. The filtered level is reduced to a one-clock press pulse on its rising edge, and only that pulse drives the sequencer. Holding the button down gives no further steps, and neither does releasing it.

The sequencer walks A, B, C, D. It stays in A, B or C until the next press. D lasts a single clock: a press pulse in that clock sends it to B, and otherwise it falls back to A. Four indicator lines show the current state one-hot. A small wrapping counter of detected press pulses shows bounce: if one physical press raises the count by more than one, the filter is too short for the button.

Top module: `button_step_seq`

## Requirements
- R1: While the asynchronous active-high reset `rst` is high, the indicators read 4'b0001 (state A) and `press_count` reads 0.
- R2: A press pulse moves A to B, B to C and C to D. Without a pulse, A, B and C keep their state.
- R3: State D lasts one clock. With a press pulse in that clock the next state is B (4'b0010); without one it is A (4'b0001).
- R4: `ind` is always one-hot: bit 0 is A, bit 1 is B, bit 2 is C, bit 3 is D.
- R5: The button passes through SYNC_STAGES flops (default 2) before the filter. With HOLD_CYCLES=4, a clean rise of `btn_raw` placed between clock edges changes `ind` at the 7th rising edge after the rise, and not earlier.
- R6: The filter takes a new level only after HOLD_CYCLES consecutive equal synchronised samples. Any pulse or drop that is shorter than this leaves the state and the counter unchanged.
- R7: Each accepted press gives exactly one single-cycle pulse. A long hold and a release, bouncy or clean, give none.
- R8: `press_count` increases by one on each press pulse and wraps modulo 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Asynchronous active-high reset |
| btn_raw | input | 1 | Raw push-button level, asynchronous |
| ind | output | 4 | One-hot state indicators (bit 0 A ... bit 3 D) |
| press_count | output | 4 | Count of detected press pulses, modulo 16 |

## Verification
The bench drives bouncy rises and falls, glitches shorter than the hold window in both directions, and holds of many tens of clocks. A design that fed the raw or merely synchronised level to the sequencer would step several times per press, or once per held clock. A design whose filter did not restart its count on each change would accept a bounce train as a press. The exact press latency is measured so that a missing or extra synchroniser stage shows up. The one-clock life of state D is checked on both exits: D with no press is checked at the top, and D with a pulse is checked by driving the sequencer submodule directly, because a filtered button cannot make two pulses in adjacent clocks. The counter is run past 16 presses to check the wrap.

// File: rtl/btnseq_pkg.sv
package btnseq_pkg;
  typedef enum logic [1:0] {
    ST_A = 2'd0,
    ST_B = 2'd1,
    ST_C = 2'd2,
    ST_D = 2'd3
  } seq_state_t;

  localparam int unsigned NUM_STATES = 4;
endpackage

// File: rtl/btnseq_sync.sv
module btnseq_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or posedge rst) begin
        if (rst) chain <= '0;
        else     chain <= din;
      end
    end else begin : g_many
      always_ff @(posedge clk or posedge rst) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/btnseq_debounce.sv
module btnseq_debounce #(
  parameter int unsigned HOLD = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic level
);
  generate
    if (HOLD == 0) begin : g_bypass
      assign level = din;
    end else begin : g_filter
      localparam int unsigned CW = (HOLD < 2) ? 1 : $clog2(HOLD);
      localparam logic [CW-1:0] LAST = CW'(HOLD - 1);
      logic [CW-1:0] run;
      logic          held;

      always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
          held <= 1'b0;
          run  <= '0;
        end else if (din == held) begin
          run <= '0;
        end else if (run == LAST) begin
          held <= din;
          run  <= '0;
        end else begin
          run <= run + 1'b1;
        end
      end

      assign level = held;
    end
  endgenerate
endmodule

// File: rtl/btnseq_fsm.sv
module btnseq_fsm
  import btnseq_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  step,
  output logic [NUM_STATES-1:0] ind
);
  seq_state_t cur, nxt;

  always_comb begin
    nxt = cur;
    unique case (cur)
      ST_A: if (step) nxt = ST_B;
      ST_B: if (step) nxt = ST_C;
      ST_C: if (step) nxt = ST_D;
      ST_D: nxt = step ? ST_B : ST_A;
      default: nxt = ST_A;
    endcase
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) cur <= ST_A;
    else     cur <= nxt;
  end

  always_comb begin
    ind = '0;
    ind[cur] = 1'b1;
  end
endmodule

// File: rtl/button_step_seq.sv
module button_step_seq #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned HOLD_CYCLES = 4,
  parameter int unsigned CNT_W       = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             btn_raw,
  output logic [3:0]       ind,
  output logic [CNT_W-1:0] press_count
);
  logic btn_sync;
  logic btn_level;
  logic level_prev;
  logic press_pulse;

  btnseq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (btn_raw),
    .dout (btn_sync)
  );

  btnseq_debounce #(.HOLD(HOLD_CYCLES)) u_deb (
    .clk   (clk),
    .rst   (rst),
    .din   (btn_sync),
    .level (btn_level)
  );

  always_ff @(posedge clk or posedge rst) begin
    if (rst) level_prev <= 1'b0;
    else     level_prev <= btn_level;
  end

  assign press_pulse = btn_level & ~level_prev;

  btnseq_fsm u_fsm (
    .clk  (clk),
    .rst  (rst),
    .step (press_pulse),
    .ind  (ind)
  );

  always_ff @(posedge clk or posedge rst) begin
    if (rst)              press_count <= '0;
    else if (press_pulse) press_count <= press_count + 1'b1;
  end
endmodule

// File: rtl/button_step_seq_chk.sv
module button_step_seq_chk #(
  parameter int unsigned CNT_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic [3:0]       ind,
  input logic [CNT_W-1:0] cnt,
  input logic             pulse
);
  assert_onehot_R4: assert property (@(posedge clk) disable iff (rst)
    $countones(ind) == 1);

  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (!pulse && ind != 4'b1000) |=> $stable(ind));

  assert_advance_R2: assert property (@(posedge clk) disable iff (rst)
    (pulse && ind == 4'b0100) |=> ind == 4'b1000);

  assert_d_fall_R3: assert property (@(posedge clk) disable iff (rst)
    (ind == 4'b1000 && !pulse) |=> ind == 4'b0001);

  assert_d_step_R3: assert property (@(posedge clk) disable iff (rst)
    (ind == 4'b1000 && pulse) |=> ind == 4'b0010);

  assert_single_R7: assert property (@(posedge clk) disable iff (rst)
    pulse |=> !pulse);

  assert_count_R8: assert property (@(posedge clk) disable iff (rst)
    pulse |=> cnt == CNT_W'($past(cnt) + 1'b1));

  assert_count_idle_R8: assert property (@(posedge clk) disable iff (rst)
    !pulse |=> $stable(cnt));
endmodule

bind button_step_seq button_step_seq_chk #(.CNT_W(CNT_W)) u_chk (
  .clk   (clk),
  .rst   (rst),
  .ind   (ind),
  .cnt   (press_count),
  .pulse (press_pulse)
);

// File: tb/button_step_seq_tb.sv
module button_step_seq_tb;
  localparam int HOLD = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       btn = 1'b0;
  logic [3:0] ind;
  logic [3:0] cnt;
  logic       fsm_step = 1'b0;
  logic [3:0] fsm_ind;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  button_step_seq #(.SYNC_STAGES(2), .HOLD_CYCLES(HOLD), .CNT_W(4)) u_dut (
    .clk(clk), .rst(rst), .btn_raw(btn), .ind(ind), .press_count(cnt)
  );

  btnseq_fsm u_fsm (
    .clk(clk), .rst(rst), .step(fsm_step), .ind(fsm_ind)
  );

  // Behavioural reference: sampled history, run length of the sampled level, press events.
  int m_state = 0;
  int m_cnt   = 0;
  int m_run   = 0;
  bit m_q0 = 0, m_q1 = 0, m_acc = 0, m_acc_d = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_state = 0; m_cnt = 0; m_run = 0;
      m_q0 = 0; m_q1 = 0; m_acc = 0; m_acc_d = 0;
    end else begin
      bit ev;
      ev = m_acc && !m_acc_d;
      if (ev) begin
        m_state = (m_state == 3) ? 1 : m_state + 1;
        m_cnt = (m_cnt + 1) % 16;
      end else if (m_state == 3) begin
        m_state = 0;
      end
      m_acc_d = m_acc;
      if (m_q1 == m_acc) m_run = 0;
      else begin
        m_run++;
        if (m_run >= HOLD) begin m_acc = m_q1; m_run = 0; end
      end
      m_q1 = m_q0;
      m_q0 = btn;
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      checks++;
      if (ind !== 4'(1 << m_state)) begin
        errors++;
        $display("FAIL R4 model ind actual %b expected %b", ind, 4'(1 << m_state));
      end
      checks++;
      if (cnt !== 4'(m_cnt)) begin
        errors++;
        $display("FAIL R8 model count actual %0d expected %0d", cnt, m_cnt);
      end
    end
  end

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic press(input int hold);
    btn = 1'b1; wait_clk(hold);
    btn = 1'b0; wait_clk(12);
  endtask

  initial begin
    #1_500_000;
    checks++; errors++;
    $display("FAIL R1 watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait_clk(3);
    check("R1 reset ind", ind, 4'b0001);
    check("R1 reset count", cnt, 4'd0);
    check("R1 reset fsm", fsm_ind, 4'b0001);
    rst = 1'b0;
    wait_clk(3);

    // R5 latency and first step
    btn = 1'b1;
    wait_clk(6);
    check("R5 not yet", ind, 4'b0001);
    wait_clk(1);
    check("R5 stepped to B", ind, 4'b0010);
    wait_clk(40);
    check("R7 long hold", ind, 4'b0010);
    btn = 1'b0; wait_clk(12);
    check("R7 release", ind, 4'b0010);
    check("R8 count one", cnt, 4'd1);

    // R6 short high glitch ignored
    btn = 1'b1; wait_clk(3); btn = 1'b0; wait_clk(12);
    check("R6 short glitch", ind, 4'b0010);
    check("R6 count kept", cnt, 4'd1);

    // R6 short drop while held gives no second press
    btn = 1'b1; wait_clk(12);
    btn = 1'b0; wait_clk(2);
    btn = 1'b1; wait_clk(12);
    check("R6 drop while held", ind, 4'b0100);
    check("R6 single count", cnt, 4'd2);
    btn = 1'b0; wait_clk(12);

    // R7 bouncy press then D lasts one clock (R3)
    btn = 1'b1; wait_clk(1); btn = 1'b0; wait_clk(2);
    btn = 1'b1; wait_clk(1); btn = 1'b0; wait_clk(1);
    btn = 1'b1;
    wait_clk(7);
    check("R3 entered D", ind, 4'b1000);
    wait_clk(1);
    check("R3 D falls to A", ind, 4'b0001);
    wait_clk(20);
    check("R7 bouncy press once", cnt, 4'd3);
    btn = 1'b0; wait_clk(1); btn = 1'b1; wait_clk(2);
    btn = 1'b0; wait_clk(1); btn = 1'b1; wait_clk(1);
    btn = 1'b0; wait_clk(20);
    check("R7 bouncy release", ind, 4'b0001);
    check("R7 bouncy release count", cnt, 4'd3);

    // R8 wrap after 16 presses
    for (int i = 0; i < 13; i++) press(8);
    check("R8 wrap count", cnt, 4'd0);
    check("R2 after 16 presses", ind, 4'b0010);
    press(8);
    check("R8 after wrap", cnt, 4'd1);
    check("R2 B to C", ind, 4'b0100);

    // R3 D with a pulse goes to B, on the sequencer driven directly
    fsm_step = 1'b1; wait_clk(3);
    check("R3 fsm in D", fsm_ind, 4'b1000);
    wait_clk(1);
    check("R3 D steps to B", fsm_ind, 4'b0010);
    fsm_step = 1'b0; wait_clk(3);
    check("R2 fsm holds B", fsm_ind, 4'b0010);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule